// File: doc/BRIEF.md
# Card Socket Status-Change Interrupt Unit

This unit serves one card socket of a two-socket host-to-card bridge. It samples the socket's live card signals through a synchronizer: both card-detect lines, both battery-voltage-detect lines, ready/busy, write-protect, wait, power-good and the card I/O interrupt request. It keeps a sticky change flag for each monitored status signal, plus one for a card access timeout reported by the access sequencer. The flags that are enabled are combined into one status-change interrupt.

The host reaches three 16-bit registers through a simple write/read port. A control word selects the socket mode, the interrupt enables and the routing. A diagnostic word can substitute register bits for most of the physical inputs. A status word shows the live signals, the sticky flags and two interrupt summaries, and its flags are cleared by writing ones. The status-change interrupt and the card I/O interrupt can each be steered to either of two active-low, level-sensitive host interrupt outputs.

There is no state machine. The unit is a synchronizer, an edge detector, a bank of sticky flags and a registered interrupt router.

Top module: `scu_socket_irq`

## Requirements
- R1: After reset, every register reads 0, address 3 reads 0 at all times, and both `host_irq_n` outputs are 1. A written control or diagnostic word reads back unchanged.
- R2: Status bits 7..0 show the synchronized live signals two clock edges after a pin change: bit 7 card-detect 2, bit 6 card-detect 1, bit 5 BVD2, bit 4 BVD1, bit 3 ready, bit 2 write-protect, bit 1 wait, bit 0 power-good. The same pins keep these positions in I/O mode, where they are read as speaker, status-change, request and 16-bit I/O.
- R3: A rising or a falling edge of a live signal sets its sticky flag on the third edge after the pin change. The flag stays set until it is cleared. Flag positions: card-detect (either line) bit 13, BVD2 bit 12, BVD1 bit 11, ready bit 10, write-protect bit 9.
- R4: A write to the status address (2) clears each flag in bits 13..8 whose written bit is 1. Flags whose written bit is 0 keep their value.
- R5: A change that arrives on the same edge as a clear of that flag leaves the flag set.
- R6: With control bit 0 = 1 (memory plus I/O), status bit 15 follows the synchronized card I/O request. With control bit 0 = 0 (memory only), bit 15 always reads 0.
- R7: Status bit 14 is 1 exactly when some flag is set and its enable is on. The enables sit in control bits 11..6 and map to flag bits 13..8 in the same order.
- R8: A one-cycle pulse on `access_timeout` sets flag bit 8 on that edge.
- R9: While diagnostic bit 8 (address 1) is set, diagnostic bits 14..9 replace card-detect 1, BVD2, BVD1, ready, write-protect and wait, in that order. The replacement shows in status and drives the flags on the next edge, and the pins for these signals have no effect. Card-detect 2, power-good and I/O request always come from the pins.
- R10: The status-change interrupt goes to host line `host_irq_n[ctl0[12]]`. The card I/O interrupt (bit 15 and enable ctl0[4]) goes to line `host_irq_n[ctl0[3]]`. Each output is active low, registered, updated one edge after its cause, and held while its cause persists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 diagnostic, 2 status, 3 none |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register |
| pin_cd1 | input | 1 | Card-detect 1 |
| pin_cd2 | input | 1 | Card-detect 2 |
| pin_bvd1 | input | 1 | Battery-detect 1 / status-change |
| pin_bvd2 | input | 1 | Battery-detect 2 / speaker |
| pin_rdy | input | 1 | Ready/busy / request |
| pin_wp | input | 1 | Write-protect / 16-bit I/O |
| pin_wait | input | 1 | Wait |
| pin_pwr | input | 1 | Power-good |
| pin_ireq | input | 1 | Card I/O interrupt request |
| access_timeout | input | 1 | One-cycle access timeout pulse |
| host_irq_n | output | 2 | Active-low host interrupt lines |

## Verification
A pin change reaches the live status bits after two clock edges, the sticky flag after three and the host interrupt output after four. A register write takes effect on the edge that captures it: live and bit-15 changes show in the read data straight after that edge, while flags caused by a diagnostic write show one edge later and interrupt outputs caused by a control write also one edge later. The bench drives every input one nanosecond after a rising edge and counts edges before it samples. At selected points it also checks one edge early, to confirm that a result has not yet arrived. The same-edge collision of a change with a clear is set up by issuing the clear write exactly two edges after the pin toggle.

// File: rtl/scu_pkg.sv
`timescale 1ns/1ps
package scu_pkg;
    localparam int REG_W   = 16;
    localparam int NPIN    = 9;
    localparam int NFLAG   = 6;
    localparam int NLINE   = 2;

    typedef enum logic [1:0] {
        ADDR_CTL0 = 2'd0,
        ADDR_CTL1 = 2'd1,
        ADDR_STAT = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    // live vector index == status bit position
    localparam int P_PWR  = 0;
    localparam int P_WAIT = 1;
    localparam int P_WP   = 2;
    localparam int P_RDY  = 3;
    localparam int P_BVD1 = 4;
    localparam int P_BVD2 = 5;
    localparam int P_CD1  = 6;
    localparam int P_CD2  = 7;
    localparam int P_IREQ = 8;

    localparam int C0_MODE   = 0;
    localparam int C0_IOLINE = 3;
    localparam int C0_IOEN   = 4;
    localparam int C0_EN_LO  = 6;
    localparam int C0_SCLINE = 12;
    localparam int C1_DIAG   = 8;
    localparam int C1_OVR_LO = 9;
    localparam int C1_OVR_HI = 14;

    localparam int ST_FLAG_LO = 8;
    localparam int ST_SUM     = 14;
    localparam int ST_IO      = 15;
endpackage

// File: rtl/scu_sync.sv
`timescale 1ns/1ps
module scu_sync #(
    parameter int WIDTH  = 9,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/scu_flags.sv
`timescale 1ns/1ps
module scu_flags #(
    parameter int NFLAG = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_ev,
    input  logic [NFLAG-1:0] clr,
    output logic [NFLAG-1:0] flag_q
);
    logic [NFLAG-1:0] flag_d;

    always_comb begin
        flag_d = (flag_q & ~clr) | set_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_chk
        p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !clr[i]) |=> flag_q[i]);
        p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set_ev[i]) |=> !flag_q[i]);
        p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
            set_ev[i] |=> flag_q[i]);
    end
endmodule

// File: rtl/scu_route.sv
`timescale 1ns/1ps
module scu_route #(
    parameter int NLINE  = 2,
    localparam int LINE_W = (NLINE > 1) ? $clog2(NLINE) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sc_req,
    input  logic [LINE_W-1:0] sc_line,
    input  logic              io_req,
    input  logic [LINE_W-1:0] io_line,
    output logic [NLINE-1:0]  irq_n
);
    for (genvar l = 0; l < NLINE; l++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_n[l] <= 1'b1;
            else        irq_n[l] <= ~((sc_req && (sc_line == LINE_W'(l))) ||
                                      (io_req && (io_line == LINE_W'(l))));
        end

        p_sc_route_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (sc_req && (sc_line == LINE_W'(l))) |=> !irq_n[l]);
        p_io_route_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (io_req && (io_line == LINE_W'(l))) |=> !irq_n[l]);
    end

    p_idle_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sc_req && !io_req) |=> (irq_n == {NLINE{1'b1}}));
endmodule

// File: rtl/scu_socket_irq.sv
`timescale 1ns/1ps
module scu_socket_irq
    import scu_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              pin_cd1,
    input  logic              pin_cd2,
    input  logic              pin_bvd1,
    input  logic              pin_bvd2,
    input  logic              pin_rdy,
    input  logic              pin_wp,
    input  logic              pin_wait,
    input  logic              pin_pwr,
    input  logic              pin_ireq,
    input  logic              access_timeout,
    output logic [NLINE-1:0]  host_irq_n
);
    localparam int OVR_W = C1_OVR_HI - C1_OVR_LO + 1;

    reg_addr_e        addr_e;
    logic [REG_W-1:0] ctl0_q, ctl1_q, status_w;
    logic [NPIN-1:0]  pins_raw, pins_sync, live, live_prev_q, edge_w;
    logic [NFLAG-1:0] set_ev, clr, flag_q, armed;
    logic             sc_req, io_posted, io_req;

    assign addr_e   = reg_addr_e'(reg_addr);
    assign pins_raw = {pin_ireq, pin_cd2, pin_cd1, pin_bvd2, pin_bvd1,
                       pin_rdy, pin_wp, pin_wait, pin_pwr};

    // control and diagnostic words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl0_q <= '0;
            ctl1_q <= '0;
        end else if (reg_we) begin
            if (addr_e == ADDR_CTL0) ctl0_q <= reg_wdata;
            if (addr_e == ADDR_CTL1) ctl1_q <= reg_wdata;
        end
    end

    scu_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d   (pins_raw),
        .q   (pins_sync)
    );

    // diagnostic substitution of wait .. card-detect 1
    always_comb begin
        live = pins_sync;
        if (ctl1_q[C1_DIAG]) begin
            live[P_CD1:P_WAIT] = ctl1_q[C1_OVR_HI:C1_OVR_LO];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_prev_q <= '0;
        else        live_prev_q <= live;
    end

    assign edge_w = live ^ live_prev_q;

    // flag index i lives at status bit ST_FLAG_LO + i
    assign set_ev = {edge_w[P_CD1] | edge_w[P_CD2], edge_w[P_BVD2], edge_w[P_BVD1],
                     edge_w[P_RDY], edge_w[P_WP], access_timeout};
    assign clr    = (reg_we && (addr_e == ADDR_STAT)) ?
                    reg_wdata[ST_FLAG_LO +: NFLAG] : '0;

    scu_flags #(.NFLAG(NFLAG)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (set_ev),
        .clr    (clr),
        .flag_q (flag_q)
    );

    assign armed     = flag_q & ctl0_q[C0_EN_LO +: NFLAG];
    assign sc_req    = |armed;
    assign io_posted = ctl0_q[C0_MODE] & live[P_IREQ];
    assign io_req    = io_posted & ctl0_q[C0_IOEN];
    assign status_w  = {io_posted, sc_req, flag_q, live[P_CD2:P_PWR]};

    always_comb begin
        unique case (addr_e)
            ADDR_CTL0: reg_rdata = ctl0_q;
            ADDR_CTL1: reg_rdata = ctl1_q;
            ADDR_STAT: reg_rdata = status_w;
            ADDR_NONE: reg_rdata = '0;
            default:   reg_rdata = '0;
        endcase
    end

    scu_route #(.NLINE(NLINE)) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .sc_req  (sc_req),
        .sc_line (ctl0_q[C0_SCLINE]),
        .io_req  (io_req),
        .io_line (ctl0_q[C0_IOLINE]),
        .irq_n   (host_irq_n)
    );

    p_mem_bit15_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl0_q[C0_MODE] |-> !status_w[ST_IO]);
    p_diag_view_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl1_q[C1_DIAG] |-> (status_w[P_CD1:P_WAIT] == ctl1_q[C1_OVR_HI -: OVR_W]));
    p_timeout_r8: assert property (@(posedge clk) disable iff (!rst_n)
        access_timeout |=> status_w[ST_FLAG_LO]);
    p_none_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_e == ADDR_NONE) |-> (reg_rdata == '0));
endmodule

// File: tb/scu_socket_irq_tb.sv
`timescale 1ns/1ps
module scu_socket_irq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic pin_cd1 = 0, pin_cd2 = 0, pin_bvd1 = 0, pin_bvd2 = 0, pin_rdy = 0;
    logic pin_wp = 0, pin_wait = 0, pin_pwr = 0, pin_ireq = 0, access_timeout = 0;
    logic [1:0]  host_irq_n;
    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    scu_socket_irq u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_cd1(pin_cd1), .pin_cd2(pin_cd2), .pin_bvd1(pin_bvd1), .pin_bvd2(pin_bvd2),
        .pin_rdy(pin_rdy), .pin_wp(pin_wp), .pin_wait(pin_wait), .pin_pwr(pin_pwr),
        .pin_ireq(pin_ireq), .access_timeout(access_timeout), .host_irq_n(host_irq_n)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        reg_addr = a;
        #0.2;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk); #1;
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(2'd0, v); chk("R1", "ctl0 reset", v, 16'h0);
        rd(2'd1, v); chk("R1", "ctl1 reset", v, 16'h0);
        rd(2'd2, v); chk("R1", "status reset", v, 16'h0);
        rd(2'd3, v); chk("R1", "addr3", v, 16'h0);
        chk("R1", "irq reset", host_irq_n, 2'b11);
        wr(2'd0, 16'hA025); rd(2'd0, v); chk("R1", "ctl0 readback", v, 16'hA025);
        wr(2'd1, 16'h0043); rd(2'd1, v); chk("R1", "ctl1 readback", v, 16'h0043);
        wr(2'd3, 16'hFFFF); rd(2'd3, v); chk("R1", "addr3 after write", v, 16'h0);
        wr(2'd0, 16'h0); wr(2'd1, 16'h0);
    endtask

    task automatic t_live_flags;
        logic [15:0] v;
        pin_cd1 = 1; pin_bvd1 = 1; pin_wait = 1; pin_pwr = 1;
        tick(1); rd(2'd2, v); chk("R2", "live one edge early", v, 16'h0);
        tick(1); rd(2'd2, v); chk("R2", "live after two edges", v, 16'h0053);
        tick(1); rd(2'd2, v); chk("R3", "rise flags cd bvd1", v, 16'h2853);
        chk("R7", "no enable no irq", host_irq_n, 2'b11);
        wr(2'd2, 16'h3F00); rd(2'd2, v); chk("R4", "clear all", v, 16'h0053);
        pin_cd1 = 0; pin_bvd1 = 0; pin_wait = 0; pin_pwr = 0;
        tick(3); rd(2'd2, v); chk("R3", "fall flags cd bvd1", v, 16'h2800);
        pin_cd2 = 1; tick(3); rd(2'd2, v); chk("R3", "cd2 sets cd flag", v, 16'h2880);
        tick(4); rd(2'd2, v); chk("R3", "flags sticky", v, 16'h2880);
        pin_cd2 = 0; tick(4); wr(2'd2, 16'h3F00);
        pin_bvd2 = 1; pin_rdy = 1; tick(3); rd(2'd2, v);
        chk("R3", "bvd2 rdy flags", v, 16'h1428);
        pin_bvd2 = 0; pin_rdy = 0; tick(4); wr(2'd2, 16'h3F00);
        rd(2'd2, v); chk("R4", "status idle", v, 16'h0);
    endtask

    task automatic t_write_zero;
        logic [15:0] v;
        pin_wp = 1; tick(4); rd(2'd2, v); chk("R3", "wp flag", v, 16'h0204);
        wr(2'd2, 16'h1000); rd(2'd2, v); chk("R4", "other bit no effect", v, 16'h0204);
        wr(2'd2, 16'h0000); rd(2'd2, v); chk("R4", "zero write no effect", v, 16'h0204);
        wr(2'd2, 16'h0200); rd(2'd2, v); chk("R4", "wp cleared", v, 16'h0004);
        pin_wp = 0; tick(4); wr(2'd2, 16'h3F00);
    endtask

    task automatic t_race;
        logic [15:0] v;
        pin_wp = 1; tick(4); rd(2'd2, v); chk("R5", "prep wp flag", v, 16'h0204);
        pin_wp = 0; tick(2);
        wr(2'd2, 16'h0200);
        rd(2'd2, v); chk("R5", "change beats clear", v, 16'h0200);
        wr(2'd2, 16'h0200);
        rd(2'd2, v); chk("R5", "later clear works", v, 16'h0000);
    endtask

    task automatic t_summary_route;
        logic [15:0] v;
        wr(2'd0, 16'h0080);
        pin_wp = 1; tick(3); rd(2'd2, v); chk("R7", "summary set", v, 16'h4204);
        chk("R10", "irq one edge early", host_irq_n, 2'b11);
        tick(1); chk("R10", "sc irq line0", host_irq_n, 2'b10);
        wr(2'd0, 16'h1080); chk("R10", "irq before reroute edge", host_irq_n, 2'b10);
        tick(1); chk("R10", "sc irq line1", host_irq_n, 2'b01);
        wr(2'd2, 16'h0200); chk("R10", "held until edge", host_irq_n, 2'b01);
        tick(1); chk("R10", "released after clear", host_irq_n, 2'b11);
        wr(2'd0, 16'h0000);
        pin_wp = 0; tick(4); rd(2'd2, v); chk("R7", "disabled flag no summary", v, 16'h0200);
        chk("R7", "disabled flag no irq", host_irq_n, 2'b11);
        wr(2'd2, 16'h3F00);
    endtask

    task automatic t_timeout;
        logic [15:0] v;
        wr(2'd0, 16'h1040);
        access_timeout = 1; tick(1); access_timeout = 0;
        rd(2'd2, v); chk("R8", "timeout flag", v, 16'h4100);
        chk("R10", "timeout irq early", host_irq_n, 2'b11);
        tick(1); chk("R8", "timeout irq line1", host_irq_n, 2'b01);
        tick(3); rd(2'd2, v); chk("R8", "timeout sticky", v, 16'h4100);
        wr(2'd2, 16'h0100); wr(2'd0, 16'h0);
    endtask

    task automatic t_diag;
        logic [15:0] v;
        wr(2'd1, 16'h4900);
        rd(2'd2, v); chk("R9", "override live", v, 16'h0048);
        tick(1); rd(2'd2, v); chk("R9", "override flags", v, 16'h2448);
        pin_bvd2 = 1; pin_cd1 = 1; tick(4); rd(2'd2, v);
        chk("R9", "pins ignored in diag", v, 16'h2448);
        wr(2'd2, 16'h3F00);
        wr(2'd1, 16'h0000);
        rd(2'd2, v); chk("R9", "pins back", v, 16'h0060);
        tick(1); rd(2'd2, v); chk("R9", "flags on return", v, 16'h1460);
        pin_bvd2 = 0; pin_cd1 = 0; tick(4); wr(2'd2, 16'h3F00);
        rd(2'd2, v); chk("R9", "idle after diag", v, 16'h0);
    endtask

    task automatic t_io;
        logic [15:0] v;
        pin_ireq = 1; tick(2); rd(2'd2, v); chk("R6", "mem mode bit15 zero", v, 16'h0);
        wr(2'd0, 16'h0019); rd(2'd2, v); chk("R6", "io mode bit15", v, 16'h8000);
        chk("R10", "io irq early", host_irq_n, 2'b11);
        tick(1); chk("R10", "io irq line1", host_irq_n, 2'b01);
        wr(2'd0, 16'h0001); chk("R10", "io irq before disable edge", host_irq_n, 2'b01);
        tick(1); chk("R10", "io irq disabled", host_irq_n, 2'b11);
        rd(2'd2, v); chk("R6", "bit15 without enable", v, 16'h8000);
        wr(2'd0, 16'h0011); tick(1); chk("R10", "io irq line0", host_irq_n, 2'b10);
        wr(2'd0, 16'h0000); rd(2'd2, v); chk("R6", "back to mem mode", v, 16'h0);
        pin_ireq = 0; tick(3);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick(1);
        t_reset();
        t_live_flags();
        t_write_zero();
        t_race();
        t_summary_route();
        t_timeout();
        t_diag();
        t_io();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog (all requirements): got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule